// File: doc/BRIEF.md
# Link Stop and Reset Command Decoder

This block sits behind a single byte-wide command register of a serial I/O link controller. Software writes a byte with a one-cycle write strobe. Three byte codes carry meaning. One code halts link transmission and holds the halt until a restart. The other two codes restart the link. Of these two restart codes, one wipes the I/O data image first and the other keeps it. Every other byte value is discarded without any visible effect.

The block drives the link engine with three signals. The first is a halt level. The second is a one-cycle restart pulse. The third is a one-cycle clear-image pulse, which always coincides with the restart it belongs to. A restart copies the current I/O-setting switch inputs into the active I/O configuration. The transmission mode and the I/O count registers are left untouched by a restart; only their own configuration write port changes them. A status output reports whether the link is currently halted.

Top module: `link_cmd_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block leaves that edge with `tx_halt`, `halted` and both pulses at 0, `io_cfg` equal to `sw_io`, `tx_mode` equal to the parameter `MODE_INIT` (default 0) and `io_count` equal to `COUNT_INIT` (default 512).
- R2: A strobed write of 8'h0F sets `tx_halt` and `halted` to 1 after that edge, and it raises neither pulse.
- R3: Once set, `tx_halt` stays at 1 through idle cycles, through repeated 8'h0F writes and through ignored writes, until a restart code is written.
- R4: A strobed write of 8'h1E raises `link_rst` and `clear_io` together for exactly one cycle after that edge, and it clears `tx_halt` in that same cycle.
- R5: A strobed write of 8'h2D raises `link_rst` for exactly one cycle after that edge, keeps `clear_io` at 0, and clears `tx_halt`.
- R6: A strobed write of any value other than 8'h0F, 8'h1E or 8'h2D changes none of the outputs.
- R7: `io_cfg` takes the value of `sw_io` only at an R1 reset or at a restart (R4/R5), and is visible in the same cycle as `link_rst`. Changes of `sw_io` at any other time do not reach `io_cfg`.
- R8: A restart leaves `tx_mode` and `io_count` unchanged. When `cfg_wr` is high at an edge, `tx_mode` and `io_count` take `mode_in` and `count_in` after that edge.
- R9: When `wr_en` is low, `wr_data` has no effect on any output, whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte |
| sw_io | input | SW_W | I/O-setting switch inputs |
| cfg_wr | input | 1 | Strobe for the mode and count write |
| mode_in | input | MODE_W | New transmission mode |
| count_in | input | CNT_W | New I/O control count |
| tx_halt | output | 1 | Transmission halt level |
| link_rst | output | 1 | One-cycle link restart pulse |
| clear_io | output | 1 | One-cycle I/O image clear pulse |
| halted | output | 1 | Status: link is halted |
| io_cfg | output | SW_W | Active I/O configuration |
| tx_mode | output | MODE_W | Transmission mode |
| io_count | output | CNT_W | I/O control count |

## Verification
Some properties are checked by the assertions on every cycle:
- `clear_io` never appears without `link_rst`.
- Neither pulse lasts longer than one cycle.
- A restart always leaves the halt level at 0.
- The halt level, `io_cfg` and the mode and count registers move only when their own strobe or a restart was present.

Other behaviour can only be shown by the bench's scenarios:
- Each specific byte code selects the correct action.
- The rejected codes near the valid ones, and a valid code written without its strobe, leave every output as it was.
- Switch changes become visible only at a restart.
- The reset values are as stated.

// File: rtl/link_cmd_pkg.sv
package link_cmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_HALT       = 8'h0F;
    localparam logic [BYTE_W-1:0] CODE_RST_CLEAR  = 8'h1E;
    localparam logic [BYTE_W-1:0] CODE_RST_KEEP   = 8'h2D;

    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,
        ACT_HALT      = 2'd1,
        ACT_RST_CLEAR = 2'd2,
        ACT_RST_KEEP  = 2'd3
    } link_act_e;

    typedef struct packed {
        logic halt;
        logic restart;
        logic wipe;
    } link_ctl_t;

    function automatic link_act_e decode_byte(input logic [BYTE_W-1:0] b);
        case (b)
            CODE_HALT:      return ACT_HALT;
            CODE_RST_CLEAR: return ACT_RST_CLEAR;
            CODE_RST_KEEP:  return ACT_RST_KEEP;
            default:        return ACT_NONE;
        endcase
    endfunction

    function automatic logic is_restart(input link_act_e a);
        return (a == ACT_RST_CLEAR) || (a == ACT_RST_KEEP);
    endfunction

endpackage

// File: rtl/link_cmd_decode.sv
module link_cmd_decode
    import link_cmd_pkg::*;
(
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output link_act_e         act
);

    always_comb begin
        if (wr_en) act = decode_byte(wr_data);
        else       act = ACT_NONE;
    end

endmodule

// File: rtl/link_ctl_seq.sv
module link_ctl_seq
    import link_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  link_act_e act,
    output link_ctl_t ctl
);

    link_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q.restart <= is_restart(act);
            ctl_q.wipe    <= (act == ACT_RST_CLEAR);
            case (act)
                ACT_HALT:                    ctl_q.halt <= 1'b1;
                ACT_RST_CLEAR, ACT_RST_KEEP: ctl_q.halt <= 1'b0;
                default:                     ctl_q.halt <= ctl_q.halt;
            endcase
        end
    end

    assign ctl = ctl_q;

    assert_wipe_with_restart_R4: assert property (@(posedge clk) disable iff (rst)
        ctl_q.wipe |-> ctl_q.restart);
    assert_restart_single_R5: assert property (@(posedge clk) disable iff (rst)
        ctl_q.restart |=> !ctl_q.restart);
    assert_restart_unhalts_R4: assert property (@(posedge clk) disable iff (rst)
        ctl_q.restart |-> !ctl_q.halt);
    assert_halt_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act) == ACT_NONE) |-> $stable(ctl_q.halt));

endmodule

// File: rtl/link_cfg_regs.sv
module link_cfg_regs #(
    parameter int                SW_W       = 8,
    parameter int                MODE_W     = 2,
    parameter int                CNT_W      = 10,
    parameter logic [MODE_W-1:0] MODE_INIT  = '0,
    parameter logic [CNT_W-1:0]  COUNT_INIT = CNT_W'(512)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic [SW_W-1:0]   sw_io,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [CNT_W-1:0]  count_in,
    output logic [SW_W-1:0]   io_cfg,
    output logic [MODE_W-1:0] tx_mode,
    output logic [CNT_W-1:0]  io_count
);

    logic [SW_W-1:0]   io_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              reload_d;

    always_ff @(posedge clk) begin
        if (rst || reload) io_q <= sw_io;
    end

    always_ff @(posedge clk) begin
        if (rst) reload_d <= 1'b0;
        else     reload_d <= reload;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_INIT;
            cnt_q  <= COUNT_INIT;
        end else if (cfg_wr) begin
            mode_q <= mode_in;
            cnt_q  <= count_in;
        end
    end

    assign io_cfg   = io_q;
    assign tx_mode  = mode_q;
    assign io_count = cnt_q;

    assert_cfg_only_on_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !reload_d) |-> $stable(io_q));
    assert_mode_only_on_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_wr)) |-> ($stable(mode_q) && $stable(cnt_q)));

endmodule

// File: rtl/link_cmd_ctrl.sv
module link_cmd_ctrl
    import link_cmd_pkg::*;
#(
    parameter int                SW_W       = 8,
    parameter int                MODE_W     = 2,
    parameter int                CNT_W      = 10,
    parameter logic [MODE_W-1:0] MODE_INIT  = '0,
    parameter logic [CNT_W-1:0]  COUNT_INIT = CNT_W'(512)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [SW_W-1:0]   sw_io,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [CNT_W-1:0]  count_in,
    output logic              tx_halt,
    output logic              link_rst,
    output logic              clear_io,
    output logic              halted,
    output logic [SW_W-1:0]   io_cfg,
    output logic [MODE_W-1:0] tx_mode,
    output logic [CNT_W-1:0]  io_count
);

    link_act_e act;
    link_ctl_t ctl;

    link_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .act     (act)
    );

    link_ctl_seq u_seq (
        .clk (clk),
        .rst (rst),
        .act (act),
        .ctl (ctl)
    );

    link_cfg_regs #(
        .SW_W       (SW_W),
        .MODE_W     (MODE_W),
        .CNT_W      (CNT_W),
        .MODE_INIT  (MODE_INIT),
        .COUNT_INIT (COUNT_INIT)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .reload   (is_restart(act)),
        .sw_io    (sw_io),
        .cfg_wr   (cfg_wr),
        .mode_in  (mode_in),
        .count_in (count_in),
        .io_cfg   (io_cfg),
        .tx_mode  (tx_mode),
        .io_count (io_count)
    );

    assign tx_halt  = ctl.halt;
    assign halted   = ctl.halt;
    assign link_rst = ctl.restart;
    assign clear_io = ctl.wipe;

endmodule

// File: tb/test_link_cmd_ctrl.sv
module test_link_cmd_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [7:0]  sw_io;
    logic        cfg_wr;
    logic [1:0]  mode_in;
    logic [9:0]  count_in;
    logic        tx_halt, link_rst, clear_io, halted;
    logic [7:0]  io_cfg;
    logic [1:0]  tx_mode;
    logic [9:0]  io_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_cmd_ctrl i_link_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .sw_io(sw_io),
        .cfg_wr(cfg_wr), .mode_in(mode_in), .count_in(count_in),
        .tx_halt(tx_halt), .link_rst(link_rst), .clear_io(clear_io), .halted(halted),
        .io_cfg(io_cfg), .tx_mode(tx_mode), .io_count(io_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at falling edge; results visible at the next falling edge
    task automatic write_byte(input logic [7:0] b, input logic strobe);
        wr_en = strobe; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; sw_io = 8'hA5;
        idle(3);
        rst = 1'b0;
        chk("R1 halt", tx_halt, 0);
        chk("R1 status", halted, 0);
        chk("R1 pulses", {link_rst, clear_io}, 0);
        chk("R1 io_cfg", io_cfg, 8'hA5);
        chk("R1 mode", tx_mode, 0);
        chk("R1 count", io_count, 512);
    endtask

    task automatic t_halt;
        write_byte(8'h0F, 1'b1);
        chk("R2 halt", tx_halt, 1);
        chk("R2 status", halted, 1);
        chk("R2 no pulse", {link_rst, clear_io}, 0);
        idle(3);
        chk("R3 idle hold", tx_halt, 1);
        write_byte(8'h0F, 1'b1);
        write_byte(8'h55, 1'b1);
        chk("R3 repeat/ignored hold", tx_halt, 1);
    endtask

    task automatic t_restart_clear;
        sw_io = 8'h3C;
        write_byte(8'h1E, 1'b1);
        chk("R4 link_rst", link_rst, 1);
        chk("R4 clear_io", clear_io, 1);
        chk("R4 halt cleared", tx_halt, 0);
        chk("R7 io_cfg loaded with restart", io_cfg, 8'h3C);
        idle(1);
        chk("R4 single pulse", {link_rst, clear_io}, 0);
    endtask

    task automatic t_restart_keep;
        write_byte(8'h0F, 1'b1);
        sw_io = 8'h81;
        write_byte(8'h2D, 1'b1);
        chk("R5 link_rst", link_rst, 1);
        chk("R5 no clear_io", clear_io, 0);
        chk("R5 halt cleared", tx_halt, 0);
        chk("R7 io_cfg keep-restart", io_cfg, 8'h81);
        idle(1);
        chk("R5 single pulse", link_rst, 0);
    endtask

    task automatic t_ignored;
        logic [7:0] bad [6] = '{8'h00, 8'h0E, 8'h1F, 8'h2C, 8'hFF, 8'h2E};
        write_byte(8'h0F, 1'b1);
        for (int i = 0; i < 6; i++) begin
            write_byte(bad[i], 1'b1);
            chk("R6 halt kept", tx_halt, 1);
            chk("R6 no pulse", {link_rst, clear_io}, 0);
        end
        write_byte(8'h2D, 1'b1);
        idle(1);
        write_byte(8'h1D, 1'b1);
        chk("R6 no halt from bad code", tx_halt, 0);
    endtask

    task automatic t_sw_isolated;
        sw_io = 8'h42;
        idle(2);
        write_byte(8'h0F, 1'b1);
        chk("R7 switch change not applied", io_cfg, 8'h81);
        write_byte(8'h2D, 1'b1);
        chk("R7 switch applied on restart", io_cfg, 8'h42);
    endtask

    task automatic t_cfg_keep;
        cfg_wr = 1'b1; mode_in = 2'd2; count_in = 10'd100;
        @(negedge clk);
        cfg_wr = 1'b0; mode_in = 2'd1; count_in = 10'd7;
        chk("R8 mode written", tx_mode, 2);
        chk("R8 count written", io_count, 100);
        write_byte(8'h1E, 1'b1);
        idle(1);
        chk("R8 mode kept over restart", tx_mode, 2);
        chk("R8 count kept over restart", io_count, 100);
    endtask

    task automatic t_no_strobe;
        sw_io = 8'h99;
        write_byte(8'h0F, 1'b0);
        chk("R9 no halt without strobe", tx_halt, 0);
        write_byte(8'h0F, 1'b1);
        write_byte(8'h1E, 1'b0);
        chk("R9 no restart without strobe", {link_rst, clear_io}, 0);
        chk("R9 halt kept", tx_halt, 1);
        chk("R9 io_cfg kept", io_cfg, 8'h42);
    endtask

    initial begin
        wr_en = 0; wr_data = 0; cfg_wr = 0; mode_in = 0; count_in = 0; sw_io = 0; rst = 1;
        @(negedge clk);
        t_reset();
        t_halt();
        t_restart_clear();
        t_restart_keep();
        t_ignored();
        t_sw_isolated();
        t_cfg_keep();
        t_no_strobe();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule